// File: doc/BRIEF.md
# Nonlinear Ratio External Clock Divider

This block derives an external master or bit clock from a fast source clock (nominally 96 MHz). Software writes a control word whose 6-bit ratio field selects the divide value. The mapping is piecewise. The lowest codes step the divisor by one, so every integer from 2 to 8 is reachable. Codes above that step it by two, so only even divisors above 8 exist. Codes that would exceed the top divisor are clamped to it.

The output is a real divided clock, registered on the source clock. An even divisor gives an exact 50% duty cycle. An odd divisor keeps its high phase one source cycle longer than its low phase. A new ratio written mid-period never shortens or stretches the period in progress. It is picked up on the source edge that closes that period.

Bit 0 of the control word selects the clock source. Clearing it picks the main source, and the divider always runs from that source. Every control bit outside the ratio field is held and read back unchanged.

Top module: `xclk_ratio_div`

## Requirements
- R1: Synchronous active-low reset, held for at least two source cycles, clears the control word to 0. The output is high while reset is held. The first period after reset uses divisor 2.
- R2: Ratio codes 0 through 6 give divisor code+2, for example code 0 gives 2, code 5 gives 7 and code 6 gives 8.
- R3: Ratio codes from 7 upward give divisor 2*code-4, for example code 7 gives 10 and code 20 gives 36. These divisors are always even.
- R4: A decoded divisor above 96 is clamped to 96. Codes 50, 51 and 63 all give a period of 96 source cycles, and no output phase ever lasts longer than 48 cycles.
- R5: For divisor d the output is high for (d+1)/2 source cycles and low for the remaining d/2 cycles (integer division). A period always starts with its high phase.
- R6: A ratio written during a period leaves that period's length and phases unchanged. The new divisor governs the period that starts at the next rising edge of the output.
- R7: A write with ctrl_we high stores all 16 bits of ctrl_wdata, and ctrl_rdata shows them after that source edge. Without a write, ctrl_rdata holds its value.
- R8: Bit 0 is the source select, where 0 means the main source. It is stored and read back, but the output is always divided from clk_src, so its value does not change the output.
- R9: The ratio field is bits [7:2] of the control word. Setting bits 1 and [15:8] does not change the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word write data |
| ctrl_rdata | output | 16 | Current control word |
| xclk_out | output | 1 | Divided clock output |

## Verification
A write is due on ctrl_rdata after the source edge that takes it, so it is checked at the following falling edge. The output changes on every source edge, and the behavioural model in the bench advances on the same rising edges. The bench compares the model and the design at each falling edge, half a period after the registers settle. A new divisor is due only after the period in progress ends. The phase measurements therefore skip to the second rising edge of the output after a write, except in the test that counts the interrupted period itself and the one after it.

// File: rtl/xdiv_pkg.sv
// Package: default dimensions for the external clock divider.
// Assumes: all users take their defaults from here so one edit retunes the block.
package xdiv_pkg;
    localparam int CTRL_W_DEF      = 16;  // control word width
    localparam int RATIO_LSB_DEF   = 2;   // ratio field position
    localparam int RATIO_W_DEF     = 6;   // ratio field width
    localparam int SMALL_LIMIT_DEF = 6;   // last code of the step-by-one range
    localparam int DIV_MAX_DEF     = 96;  // largest divisor
endpackage

// File: rtl/xdiv_ctrl_reg.sv
// Module: control word register.
// Assumes: synchronous active-low reset; every bit is stored verbatim.
module xdiv_ctrl_reg #(
    parameter int          CTRL_W    = 16,
    parameter logic [CTRL_W-1:0] RESET_VAL = '0
) (
    input  logic              clk_src,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] q
);
    // Store a written word; hold otherwise.
    always_ff @(posedge clk_src) begin
        if (!rst_n)
            q <= RESET_VAL;
        else if (wr_en)
            q <= wr_data;
    end
endmodule

// File: rtl/xdiv_ratio_decode.sv
// Module: maps a ratio code onto a divisor, step one then step two, clamped.
// Assumes: purely combinational; SMALL_LIMIT+2 is the last step-by-one divisor.
module xdiv_ratio_decode #(
    parameter int RATIO_W     = 6,
    parameter int DIV_W       = 7,
    parameter int SMALL_LIMIT = 6,
    parameter int DIV_MAX     = 96
) (
    input  logic [RATIO_W-1:0] ratio,
    output logic [DIV_W-1:0]   divisor
);
    localparam int CALC_W = RATIO_W + 2;

    logic [CALC_W-1:0] r_ext;
    logic [CALC_W-1:0] raw;

    assign r_ext = CALC_W'(ratio);

    // Piecewise mapping before clamping.
    always_comb begin
        if (r_ext <= CALC_W'(SMALL_LIMIT))
            raw = r_ext + CALC_W'(2);
        else
            raw = ((r_ext - CALC_W'(SMALL_LIMIT)) << 1) + CALC_W'(SMALL_LIMIT + 2);
    end

    // Clamp to the largest usable divisor.
    assign divisor = (raw > CALC_W'(DIV_MAX)) ? DIV_W'(DIV_MAX) : DIV_W'(raw);
endmodule

// File: rtl/xdiv_phase_gen.sv
// Module: counts source cycles and produces the registered divided clock.
// Assumes: next_div >= 2 and is only sampled at the end of a period; reset is
// held for two or more cycles so next_div is settled when it is loaded.
module xdiv_phase_gen #(
    parameter int DIV_W = 7
) (
    input  logic             clk_src,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] next_div,
    output logic             clk_out
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] cur_div;
    logic [DIV_W:0]   div_p1;
    logic [DIV_W-1:0] hi_len;
    logic             last;

    // High phase length is ceil(cur_div/2).
    assign div_p1 = (DIV_W+1)'(cur_div) + (DIV_W+1)'(1);
    assign hi_len = div_p1[DIV_W:1];
    assign last   = (cnt == cur_div - DIV_W'(1));

    // Advance the position; reload the divisor and go high at each boundary.
    always_ff @(posedge clk_src) begin
        if (!rst_n) begin
            cnt     <= '0;
            cur_div <= next_div;
            clk_out <= 1'b1;
        end else if (last) begin
            cnt     <= '0;
            cur_div <= next_div;
            clk_out <= 1'b1;
        end else begin
            cnt     <= cnt + DIV_W'(1);
            clk_out <= (cnt + DIV_W'(1)) < hi_len;
        end
    end
endmodule

// File: rtl/xclk_ratio_div.sv
// Module: top of the external clock divider (control word plus divider).
// Assumes: bit 0 is a stored source select only; the divider always runs on clk_src.
module xclk_ratio_div
    import xdiv_pkg::*;
#(
    parameter int CTRL_W      = CTRL_W_DEF,
    parameter int RATIO_LSB   = RATIO_LSB_DEF,
    parameter int RATIO_W     = RATIO_W_DEF,
    parameter int SMALL_LIMIT = SMALL_LIMIT_DEF,
    parameter int DIV_MAX     = DIV_MAX_DEF
) (
    input  logic              clk_src,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    output logic              xclk_out
);
    localparam int DIV_W = $clog2(DIV_MAX + 1);

    logic [CTRL_W-1:0]  ctrl_q;
    logic [RATIO_W-1:0] ratio;
    logic [DIV_W-1:0]   divisor;

    xdiv_ctrl_reg #(.CTRL_W(CTRL_W), .RESET_VAL('0)) u_ctrl (
        .clk_src (clk_src),
        .rst_n   (rst_n),
        .wr_en   (ctrl_we),
        .wr_data (ctrl_wdata),
        .q       (ctrl_q)
    );

    assign ratio      = ctrl_q[RATIO_LSB +: RATIO_W];
    assign ctrl_rdata = ctrl_q;

    xdiv_ratio_decode #(
        .RATIO_W(RATIO_W), .DIV_W(DIV_W),
        .SMALL_LIMIT(SMALL_LIMIT), .DIV_MAX(DIV_MAX)
    ) u_dec (
        .ratio   (ratio),
        .divisor (divisor)
    );

    xdiv_phase_gen #(.DIV_W(DIV_W)) u_phase (
        .clk_src  (clk_src),
        .rst_n    (rst_n),
        .next_div (divisor),
        .clk_out  (xclk_out)
    );
endmodule

// File: rtl/xdiv_checker.sv
// Module: property checker for the external clock divider, bound to the top.
// Assumes: observes ports only; phase lengths are tracked with local counters.
module xdiv_checker #(
    parameter int CTRL_W  = 16,
    parameter int DIV_MAX = 96
) (
    input logic              clk_src,
    input logic              rst_n,
    input logic              ctrl_we,
    input logic [CTRL_W-1:0] ctrl_wdata,
    input logic [CTRL_W-1:0] ctrl_rdata,
    input logic              xclk_out
);
    localparam int HALF_MAX = (DIV_MAX + 1) / 2;

    logic        prev_q;
    logic [15:0] run_q;
    logic [15:0] last_hi_q;
    logic        seen_rise_q;
    logic        hi_valid_q;

    // Track the length of the current output phase and the last full high phase.
    always_ff @(posedge clk_src) begin
        if (!rst_n) begin
            prev_q      <= 1'b1;
            run_q       <= '0;
            last_hi_q   <= '0;
            seen_rise_q <= 1'b0;
            hi_valid_q  <= 1'b0;
        end else begin
            prev_q <= xclk_out;
            if (xclk_out == prev_q)
                run_q <= run_q + 16'd1;
            else
                run_q <= 16'd1;
            if (prev_q && !xclk_out) begin
                last_hi_q  <= run_q;
                hi_valid_q <= seen_rise_q;
            end
            if (!prev_q && xclk_out)
                seen_rise_q <= 1'b1;
        end
    end

    AST_WRITE_READBACK: assert property (@(posedge clk_src) disable iff (!rst_n)
        ctrl_we |=> (ctrl_rdata == $past(ctrl_wdata)));                      // R7

    AST_HOLD_NO_WRITE: assert property (@(posedge clk_src) disable iff (!rst_n)
        !ctrl_we |=> $stable(ctrl_rdata));                                  // R7

    AST_PHASE_MAX: assert property (@(posedge clk_src) disable iff (!rst_n)
        run_q <= 16'(HALF_MAX));                                            // R4

    AST_PHASE_BALANCE: assert property (@(posedge clk_src) disable iff (!rst_n)
        (!prev_q && xclk_out && hi_valid_q) |->
        ((last_hi_q == run_q) || (last_hi_q == run_q + 16'd1)));             // R5
endmodule

bind xclk_ratio_div xdiv_checker #(.CTRL_W(CTRL_W), .DIV_MAX(DIV_MAX)) u_chk (
    .clk_src    (clk_src),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .ctrl_rdata (ctrl_rdata),
    .xclk_out   (xclk_out)
);

// File: tb/tb_xclk_ratio_div.sv
// Bench: behavioural reference model compared on every source cycle, plus
// phase-length measurements for chosen ratio codes.
module tb_xclk_ratio_div;
    localparam int CLK_PERIOD = 10;

    logic        clk_src    = 1'b0;
    logic        rst_n      = 1'b0;
    logic        ctrl_we    = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic [15:0] ctrl_rdata;
    logic        xclk_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk_src = ~clk_src;

    xclk_ratio_div dut (
        .clk_src    (clk_src),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_rdata (ctrl_rdata),
        .xclk_out   (xclk_out)
    );

    // Divisor expected for a ratio code (R2, R3, R4).
    function automatic int exp_div(int code);
        int d;
        if (code < 7) d = code + 2;
        else          d = 8 + 2 * (code - 6);
        if (d > 96) d = 96;
        return d;
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model state, advanced on the same rising edges as the design.
    int m_ctl = 0;
    int m_pos = 0;
    int m_div = 2;

    always @(posedge clk_src) begin
        if (!rst_n) begin
            m_ctl = 0;
            m_pos = 0;
            m_div = 2;
        end else begin
            if (m_pos == m_div - 1) begin
                m_pos = 0;
                m_div = exp_div((m_ctl >> 2) & 63);
            end else begin
                m_pos++;
            end
            if (ctrl_we) m_ctl = int'(ctrl_wdata);
        end
    end

    // Compare the model on every falling edge.
    always @(negedge clk_src) begin
        if (rst_n && !done) begin
            chk("R6 per-cycle output", int'(xclk_out), (m_pos < (m_div + 1) / 2) ? 1 : 0);
            chk("R7 per-cycle readback", int'(ctrl_rdata), m_ctl);
        end
    end

    task automatic write_ctl(logic [15:0] v);
        @(negedge clk_src);
        ctrl_wdata = v;
        ctrl_we    = 1'b1;
        @(negedge clk_src);
        ctrl_we    = 1'b0;
        chk("R7 write readback", int'(ctrl_rdata), int'(v));
    endtask

    // Return at the falling edge holding the first high sample of a period.
    task automatic wait_rise();
        bit p;
        @(negedge clk_src);
        p = xclk_out;
        forever begin
            @(negedge clk_src);
            if (!p && xclk_out) break;
            p = xclk_out;
        end
    endtask

    task automatic count_period(output int hi, output int lo);
        hi = 0;
        lo = 0;
        while (xclk_out) begin hi++; @(negedge clk_src); end
        while (!xclk_out) begin lo++; @(negedge clk_src); end
    endtask

    task automatic measure(string tag, int ehi, int elo);
        int hi, lo;
        wait_rise();
        wait_rise();
        count_period(hi, lo);
        chk({tag, " high cycles"}, hi, ehi);
        chk({tag, " low cycles"}, lo, elo);
    endtask

    initial begin
        int hi, lo;
        repeat (3) @(negedge clk_src);
        chk("R1 reset readback", int'(ctrl_rdata), 0);
        chk("R1 reset output high", int'(xclk_out), 1);
        rst_n = 1'b1;
        measure("R1 divisor 2 after reset", 1, 1);

        write_ctl(16'(1 << 2));  measure("R5 code 1 divisor 3", 2, 1);
        write_ctl(16'(5 << 2));  measure("R2 code 5 divisor 7", 4, 3);
        write_ctl(16'(6 << 2));  measure("R2 code 6 divisor 8", 4, 4);
        write_ctl(16'(7 << 2));  measure("R3 code 7 divisor 10", 5, 5);
        write_ctl(16'(20 << 2)); measure("R3 code 20 divisor 36", 18, 18);
        write_ctl(16'(50 << 2)); measure("R4 code 50 divisor 96", 48, 48);
        write_ctl(16'(51 << 2)); measure("R4 code 51 clamped", 48, 48);
        write_ctl(16'(63 << 2)); measure("R4 code 63 clamped", 48, 48);

        write_ctl(16'h0008);     measure("R8 select 0 code 2", 2, 2);
        write_ctl(16'h0009);     measure("R8 select 1 code 2", 2, 2);
        write_ctl(16'hFF02);     measure("R9 outside bits code 0", 1, 1);
        write_ctl(16'hF00F);     measure("R9 code 3 with extras", 3, 2);

        // R6: write mid-period; current period keeps divisor 70.
        write_ctl(16'(37 << 2)); measure("R6 code 37 divisor 70", 35, 35);
        wait_rise();
        ctrl_wdata = 16'(1 << 2);
        ctrl_we    = 1'b1;
        hi = 0;
        while (xclk_out) begin
            hi++;
            @(negedge clk_src);
            ctrl_we = 1'b0;
        end
        lo = 0;
        while (!xclk_out) begin lo++; @(negedge clk_src); end
        chk("R6 interrupted period high", hi, 35);
        chk("R6 interrupted period low", lo, 35);
        count_period(hi, lo);
        chk("R6 next period high", hi, 2);
        chk("R6 next period low", lo, 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_src);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule